// File: doc/BRIEF.md
# Hot-Swap Switch Mode Controller

This block sequences the high-voltage switch that joins a powered device's line-side interface to its downstream dc-dc converter. It works only on digitized flags. These are a lockout-release flag from the undervoltage comparator, two flags from the comparators on the voltage across the switch (below the turn-on level, above the overload level), the classification type and a go signal from the classification logic, and a free-running timebase tick. From these it picks one of four switch modes: disconnected, current-limited inrush, fully conducting, and low-limit overload. It also raises a converter enable.

Leaving inrush depends on the classification type. A Type 1 device closes the switch as soon as the input capacitor is charged. Types 2, 3 and 4 must also spend a minimum dwell in inrush. An overload is declared only when the over-threshold flag persists for a filter window, and recovery from overload needs the same minimum dwell plus a charged capacitor. Both windows are parameters counted in timebase ticks.

Top module: `hsw_ctrl`

## Requirements
- R1: During and after reset the controller is in the disconnected mode: `mode_off_o`=1, every other mode output and `conv_en_o` are 0.
- R2: Whenever `uvlo_ok_i` is 0, the next cycle shows the disconnected mode, whatever the previous mode was.
- R3: The disconnected mode is left only when `uvlo_ok_i` and `seq_en_i` are both 1 in the same cycle, and it is left for inrush.
- R4: With `pd_type_i`=0 (Type 1), inrush moves to fully-on in the cycle after `vsw_low_i` is seen in inrush, with no dwell.
- R5: With `pd_type_i` of 1, 2 or 3 (Types 2, 3 and 4), inrush moves to fully-on only when `vsw_low_i`=1 and at least DWELL_TICKS ticks have passed since inrush was entered. With the tick present every cycle and `vsw_low_i` held at 1, inrush lasts DWELL_TICKS+1 cycles.
- R6: Fully-on moves to overload when `vsw_high_i` has been 1 for FILT_TICKS consecutive ticks. With the tick present every cycle, fully-on shows for FILT_TICKS cycles after the flag rises.
- R7: Any cycle with `vsw_high_i`=0 restarts the persistence window, so high runs shorter than FILT_TICKS never cause overload.
- R8: Overload returns to fully-on only when `vsw_low_i`=1 and at least DWELL_TICKS ticks have passed since this overload entry. The dwell restarts on every entry.
- R9: `conv_en_o` is 1 exactly when the fully-on mode is shown.
- R10: Dwell and persistence counts advance only in cycles where `tick_i`=1. With no tick, inrush of Types 2 to 4 is never left.
- R11: Exactly one of the four mode outputs is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase tick that advances dwell and persistence counts |
| uvlo_ok_i | input | 1 | 1 = input voltage above lockout, lockout released |
| seq_en_i | input | 1 | 1 = detection and classification finished, switch may start |
| pd_type_i | input | 2 | Classification type: 0 = Type 1, 1 = Type 2, 2 = Type 3, 3 = Type 4 |
| vsw_low_i | input | 1 | 1 = switch voltage below the turn-on level (capacitor charged) |
| vsw_high_i | input | 1 | 1 = switch voltage above the overload level |
| mode_off_o | output | 1 | Switch disconnected |
| mode_inrush_o | output | 1 | Closed-loop inrush current limit |
| mode_on_o | output | 1 | Switch fully conducting |
| mode_ovld_o | output | 1 | Low current-limit overload mode |
| conv_en_o | output | 1 | Downstream converter enable |

## Verification
The bench builds the controller with DWELL_TICKS=20 and FILT_TICKS=6 in place of the 80 ms and 140 µs defaults. This lets the exact length of each inrush and overload dwell, and of each persistence window, be counted cycle by cycle. Glitch trains one tick short of the filter window, dwells stalled by a missing tick, and repeated overload entries all fit in a short run at these values.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [1:0] {
        SW_OFF    = 2'd0,
        SW_INRUSH = 2'd1,
        SW_ON     = 2'd2,
        SW_OVLD   = 2'd3
    } hsw_state_e;

    // classification type code; only the first value skips the inrush dwell
    localparam logic [1:0] PD_TYPE1 = 2'd0;

    typedef struct packed {
        hsw_state_e state;
    } hsw_regs_s;

endpackage

// File: rtl/hsw_tick_counter.sv
module hsw_tick_counter #(
    parameter int unsigned LIMIT = 16,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic tick_i,
    output logic done_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done_o = (cnt_q == CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && !done_o) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R10: no tick and no restart leaves the count untouched
    assert_hold_no_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clear_i) |=> $stable(cnt_q));

    // R10: a saturated window stays reached until restarted
    assert_sat_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !clear_i) |=> done_o);

endmodule

// File: rtl/hsw_step.sv
module hsw_step
    import hsw_pkg::*;
(
    input  hsw_state_e  state_i,
    input  logic        uvlo_ok_i,
    input  logic        seq_en_i,
    input  logic [1:0]  pd_type_i,
    input  logic        vsw_low_i,
    input  logic        dwell_done_i,
    input  logic        filt_done_i,
    output hsw_state_e  state_o
);

    logic skip_dwell;

    assign skip_dwell = (pd_type_i == PD_TYPE1);

    always_comb begin
        state_o = state_i;
        if (!uvlo_ok_i) begin
            state_o = SW_OFF;
        end else begin
            unique case (state_i)
                SW_OFF: begin
                    if (seq_en_i) state_o = SW_INRUSH;
                end
                SW_INRUSH: begin
                    if (vsw_low_i && (skip_dwell || dwell_done_i)) state_o = SW_ON;
                end
                SW_ON: begin
                    if (filt_done_i) state_o = SW_OVLD;
                end
                SW_OVLD: begin
                    if (vsw_low_i && dwell_done_i) state_o = SW_ON;
                end
                default: state_o = SW_OFF;
            endcase
        end
    end

endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
    import hsw_pkg::*;
#(
    parameter int unsigned DWELL_TICKS = 16_000_000,
    parameter int unsigned FILT_TICKS  = 28_000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       uvlo_ok_i,
    input  logic       seq_en_i,
    input  logic [1:0] pd_type_i,
    input  logic       vsw_low_i,
    input  logic       vsw_high_i,
    output logic       mode_off_o,
    output logic       mode_inrush_o,
    output logic       mode_on_o,
    output logic       mode_ovld_o,
    output logic       conv_en_o
);

    hsw_regs_s  regs_d, regs_q;
    hsw_state_e step_state;
    logic       dwell_done, filt_done;
    logic       dwell_clear, filt_clear;

    hsw_step i_step (
        .state_i      (regs_q.state),
        .uvlo_ok_i    (uvlo_ok_i),
        .seq_en_i     (seq_en_i),
        .pd_type_i    (pd_type_i),
        .vsw_low_i    (vsw_low_i),
        .dwell_done_i (dwell_done),
        .filt_done_i  (filt_done),
        .state_o      (step_state)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = step_state;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q.state <= SW_OFF;
        end else begin
            regs_q <= regs_d;
        end
    end

    // dwell window restarts on every state change
    assign dwell_clear = (regs_d.state != regs_q.state);
    // persistence window restarts when the flag drops or outside fully-on
    assign filt_clear  = !vsw_high_i || (regs_q.state != SW_ON);

    hsw_tick_counter #(.LIMIT(DWELL_TICKS)) i_dwell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (dwell_clear),
        .tick_i  (tick_i),
        .done_o  (dwell_done)
    );

    hsw_tick_counter #(.LIMIT(FILT_TICKS)) i_filt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (filt_clear),
        .tick_i  (tick_i),
        .done_o  (filt_done)
    );

    assign mode_off_o    = (regs_q.state == SW_OFF);
    assign mode_inrush_o = (regs_q.state == SW_INRUSH);
    assign mode_on_o     = (regs_q.state == SW_ON);
    assign mode_ovld_o   = (regs_q.state == SW_OVLD);
    assign conv_en_o     = (regs_q.state == SW_ON);

    assert_lockout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !uvlo_ok_i |=> mode_off_o);

    assert_start_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_off_o && !(uvlo_ok_i && seq_en_i)) |=> mode_off_o);

    assert_off_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_off_o |=> (mode_off_o || mode_inrush_o));

    assert_on_needs_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mode_on_o) |-> $past(vsw_low_i));

    assert_inrush_dwell_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(mode_on_o) && $past(mode_inrush_o) && ($past(pd_type_i) != PD_TYPE1))
        |-> $past(dwell_done));

    assert_ovld_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mode_ovld_o) |-> ($past(mode_on_o) && $past(filt_done)));

    assert_ovld_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(mode_ovld_o) && mode_on_o) |-> $past(dwell_done));

    assert_conv_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(conv_en_o) |-> $past(mode_inrush_o || mode_ovld_o));

endmodule

// File: tb/test_hsw_ctrl.sv
module test_hsw_ctrl;

    localparam int DWELL = 20;
    localparam int FILT  = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick, uvlo_ok, seq_en, vsw_low, vsw_high;
    logic [1:0] pd_type;
    logic       m_off, m_inr, m_on, m_ovl, conv_en;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hsw_ctrl #(.DWELL_TICKS(DWELL), .FILT_TICKS(FILT)) i_hsw_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .uvlo_ok_i(uvlo_ok),
        .seq_en_i(seq_en), .pd_type_i(pd_type), .vsw_low_i(vsw_low),
        .vsw_high_i(vsw_high), .mode_off_o(m_off), .mode_inrush_o(m_inr),
        .mode_on_o(m_on), .mode_ovld_o(m_ovl), .conv_en_o(conv_en)
    );

    function automatic logic [3:0] modes();
        return {m_ovl, m_on, m_inr, m_off};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input logic [3:0] exp);
        chk(modes() == exp, req, int'(modes()), int'(exp));
        chk($countones(modes()) == 1, "R11", $countones(modes()), 1);
        chk(conv_en == exp[2], "R9", int'(conv_en), int'(exp[2]));
    endtask

    // counts samples while the chosen mode bit stays high (starts next negedge)
    task automatic count_while(input int bitsel, output int n);
        n = 0;
        @(negedge clk);
        while (modes()[bitsel] && n < 10 * DWELL) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic go_off();
        uvlo_ok = 1'b0; seq_en = 1'b0; vsw_low = 1'b0; vsw_high = 1'b0; tick = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic start(input logic [1:0] typ, input logic low);
        go_off();
        pd_type = typ; vsw_low = low; uvlo_ok = 1'b1; seq_en = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick = 1'b1; uvlo_ok = 1'b1; seq_en = 1'b1;
        pd_type = 2'd0; vsw_low = 1'b1; vsw_high = 1'b0;
        repeat (3) @(negedge clk);
        chk_mode("R1 in reset", 4'b0001);
        rst_n = 1'b1;
        uvlo_ok = 1'b0;
        @(negedge clk);
        chk_mode("R1 after reset", 4'b0001);
    endtask

    task automatic t_seq_gate();
        go_off();
        uvlo_ok = 1'b1; seq_en = 1'b0;
        repeat (5) @(negedge clk);
        chk_mode("R3 no go signal", 4'b0001);
        uvlo_ok = 1'b0; seq_en = 1'b1;
        repeat (5) @(negedge clk);
        chk_mode("R3 lockout held", 4'b0001);
        uvlo_ok = 1'b1;
        @(negedge clk);
        chk_mode("R3 both present", 4'b0010);
    endtask

    task automatic t_type1();
        int n;
        start(2'd0, 1'b1);
        count_while(1, n);
        chk(n == 1, "R4 type1 inrush length", n, 1);
        chk_mode("R4 type1 on", 4'b0100);
        start(2'd0, 1'b0);
        repeat (DWELL + 4) @(negedge clk);
        chk_mode("R4 waits for low flag", 4'b0010);
        vsw_low = 1'b1;
        @(negedge clk);
        chk_mode("R4 on right after low", 4'b0100);
    endtask

    task automatic t_typeN();
        int n;
        start(2'd1, 1'b1);
        count_while(1, n);
        chk(n == DWELL + 1, "R5 type2 dwell", n, DWELL + 1);
        chk_mode("R5 type2 on", 4'b0100);
        start(2'd3, 1'b1);
        @(negedge clk);
        chk_mode("R5 type4 inrush no converter", 4'b0010);
        count_while(1, n);
        chk(n == DWELL, "R5 type4 dwell", n, DWELL);
    endtask

    task automatic t_tick();
        int n;
        start(2'd2, 1'b1);
        tick = 1'b0;
        repeat (3 * DWELL) @(negedge clk);
        chk_mode("R10 stalled dwell", 4'b0010);
        tick = 1'b1;
        n = 0;
        while (m_inr && n < 10 * DWELL) begin
            n++;
            @(negedge clk);
        end
        chk(n == DWELL + 1, "R10 dwell after stall", n, DWELL + 1);
    endtask

    task automatic t_filter();
        start(2'd0, 1'b1);
        repeat (3) @(negedge clk);
        vsw_low = 1'b0;
        for (int k = 0; k < 3; k++) begin
            vsw_high = 1'b1;
            repeat (FILT - 1) @(negedge clk);
            vsw_high = 1'b0;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk_mode("R7 short runs ignored", 4'b0100);
    endtask

    task automatic t_ovld();
        int n;
        // continues from fully-on
        vsw_high = 1'b1;
        count_while(2, n);
        chk(n == FILT, "R6 persistence length", n, FILT);
        chk_mode("R6 overload", 4'b1000);
        vsw_high = 1'b0; vsw_low = 1'b0;
        repeat (DWELL + 5) @(negedge clk);
        chk_mode("R8 no low flag stays", 4'b1000);
        vsw_low = 1'b1;
        @(negedge clk);
        chk_mode("R8 recovered", 4'b0100);
        vsw_low = 1'b0; vsw_high = 1'b1;
        count_while(2, n);
        chk(n == FILT, "R6 second entry", n, FILT);
        vsw_high = 1'b0; vsw_low = 1'b1;
        count_while(3, n);
        chk(n == DWELL, "R8 dwell restarted", n, DWELL);
        chk_mode("R8 on again", 4'b0100);
    endtask

    task automatic t_lockout();
        start(2'd1, 1'b0);
        repeat (3) @(negedge clk);
        uvlo_ok = 1'b0;
        @(negedge clk);
        chk_mode("R2 from inrush", 4'b0001);
        start(2'd0, 1'b1);
        repeat (3) @(negedge clk);
        uvlo_ok = 1'b0;
        @(negedge clk);
        chk_mode("R2 from on", 4'b0001);
        start(2'd0, 1'b1);
        repeat (3) @(negedge clk);
        vsw_low = 1'b0; vsw_high = 1'b1;
        repeat (FILT + 2) @(negedge clk);
        chk_mode("R2 setup overload", 4'b1000);
        uvlo_ok = 1'b0;
        @(negedge clk);
        chk_mode("R2 from overload", 4'b0001);
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_seq_gate();
        t_type1();
        t_typeN();
        t_tick();
        t_filter();
        t_ovld();
        t_lockout();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule